// File: doc/BRIEF.md
# Slot Serial Output Shifter

This block sits at the output side of a time-slotted voice transcoder. In each slot, upstream logic hands over one finished result. That result is either a compressed code of 2 to 5 bits, bound for the code transmit line, or a PCM byte, bound for the PCM receive line. The hand-over happens when the slot strobe `ce` falls. During the next strobe-high window, the block sends that word MSB first on the line the word was meant for. It steps one bit on every rising edge of that line's own bit clock. When the bit clock delivers more edges than the word has bits, the block starts the word again from the top.

Each line comes as a data bit plus a drive enable, which stands in for the three-state pad. The enable is raised only while the strobe is high, and only on the line chosen for the slot. A slot marked inactive sends a fixed idle pattern. On the code line that pattern is all zeros, of the length the rate mode sets. On the PCM line it depends on the companding law. All strobe and bit-clock inputs are asynchronous and pass through synchronizers in front of `clk`.

The word hand-over is a valid/ready port. `in_ready` is a one-cycle pulse in the cycle where the strobe's falling edge is seen. The word is taken only if `in_valid` is high in that same cycle. The source must therefore hold `in_valid` and its fields steady until it sees `in_ready`. If no word is taken at a falling edge, neither line drives in the following window. No other form of back-pressure exists.

Top module: `slot_serial_out`

## Requirements
- R1: `in_ready` is high for exactly one `clk` cycle after each falling edge of `ce`. A word is taken when `in_valid` and `in_ready` are both high. If no word is taken, neither `tso_oe` nor `rso_oe` rises in the next `ce`-high window.
- R2: `tso_oe`/`rso_oe` are high only while `ce` is high and only for a taken word. `in_dir`=1 selects the code line (`tso`) and `in_dir`=0 selects the PCM line (`rso`). The two enables are never high together.
- R3: When `ce` rises, the line shows the word's MSB. Each rising edge of its own bit clock while `ce` is high moves to the next bit: `asck` for `tso`, `psck` for `rso`. Edges of the other bit clock leave the line unchanged.
- R4: In rate mode 2'b00, the code is `in_code[3:0]`. `tso` sends D3 D2 D1 D0 and then repeats from D3.
- R5: In rate mode 2'b01, the code is `in_code[2:0]` and `tso` sends D2 D1 D0 0. In rate mode 2'b10, the code is `in_code[1:0]` and `tso` sends D1 D0 0 0. Both repeat every 4 bits, and unused upper code bits have no effect.
- R6: In rate mode 2'b11, `tso` sends `in_code[4:0]` as D4..D0 and returns to D4 on the fifth bit-clock edge.
- R7: `rso` sends `in_pcm` MSB first and returns to bit 7 after the eighth bit has been sent (on the eighth `psck` rising edge).
- R8: A taken code-line word with `in_en`=0 sends only zeros: 4 bits, or 5 in rate mode 2'b11.
- R9: A taken PCM-line word with `in_en`=0 sends 8'hFF when `in_law`=0 and 8'hD5 when `in_law`=1, whatever `in_pcm` holds.
- R10: After reset, both enables, both data lines and `in_ready` are low.
- R11: A data line is low whenever its enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Slot strobe (asynchronous) |
| asck | input | 1 | Code-line bit clock (asynchronous) |
| psck | input | 1 | PCM-line bit clock (asynchronous) |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word taken this cycle if valid |
| in_dir | input | 1 | 1 = code line, 0 = PCM line |
| in_en | input | 1 | 1 = live channel, 0 = send idle pattern |
| in_law | input | 1 | Idle PCM law: 0 = mu-law, 1 = A-law |
| in_rate | input | 2 | Code rate mode: 00, 01, 10, 11 as in R4–R6 |
| in_code | input | 5 | Compressed code, right-justified |
| in_pcm | input | 8 | PCM byte |
| tso | output | 1 | Code-line serial data |
| tso_oe | output | 1 | Code-line drive enable |
| rso | output | 1 | PCM-line serial data |
| rso_oe | output | 1 | PCM-line drive enable |

## Verification
The bench targets the point where each word wraps: after 4, 5 or 8 bits. A wrong length counter would repeat a bit or drift into stale data. Filler positions in the short modes are checked as zero with the upper code bits set to one, which catches a formatter that fails to mask. Idle slots are run with live-looking data on the inputs, so a design that ignored the enable would leak that data. Further cases cover a pulse on the wrong bit clock, which a shared advance would act on, and a strobe fall with no word offered, which a design that keeps stale state would answer by driving a line.

// File: rtl/slot_ser_pkg.sv
package slot_ser_pkg;

  typedef enum logic [1:0] {
    RATE_4B = 2'b00,
    RATE_3B = 2'b01,
    RATE_2B = 2'b10,
    RATE_5B = 2'b11
  } rate_e;

  // number of significant code bits for each rate mode
  function automatic int rate_bits(rate_e r);
    case (r)
      RATE_4B: rate_bits = 4;
      RATE_3B: rate_bits = 3;
      RATE_2B: rate_bits = 2;
      default: rate_bits = 5;
    endcase
  endfunction

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [STAGES-1:0][N-1:0] stg;
  logic [N-1:0]             q_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end
  endgenerate

  assign q = stg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_d <= '0;
    else        q_d <= q;

  assign rise = q & ~q_d;
  assign fall = ~q & q_d;

endmodule

// File: rtl/slot_code_fmt.sv
module slot_code_fmt
  import slot_ser_pkg::*;
#(
  parameter int CODE_W = 5,
  localparam int LW    = $clog2(CODE_W + 1)
) (
  input  rate_e             rate,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] frame,
  output logic [LW-1:0]     len
);

  always_comb begin
    int nb;
    nb    = rate_bits(rate);
    frame = '0;
    // left-justify the significant bits, filler positions stay zero
    for (int i = 0; i < CODE_W; i++) begin
      if (en && (i < nb)) frame[CODE_W-1-i] = code[nb-1-i];
    end
    len = (rate == RATE_5B) ? LW'(CODE_W) : LW'(CODE_W - 1);
  end

endmodule

// File: rtl/slot_serializer.sv
module slot_serializer #(
  parameter int W   = 8,
  localparam int PW = $clog2(W),
  localparam int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  word,
  input  logic [LW-1:0] len,
  input  logic          start,
  input  logic          adv,
  output logic          bit_o
);

  logic [W-1:0]  word_q;
  logic [LW-1:0] len_q;
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      len_q  <= LW'(W);
      ptr    <= '0;
    end else if (load) begin
      word_q <= word;
      len_q  <= len;
      ptr    <= '0;
    end else if (start) begin
      ptr <= '0;
    end else if (adv) begin
      if (LW'(ptr) + LW'(1) >= len_q) ptr <= '0;
      else                            ptr <= ptr + PW'(1);
    end
  end

  assign bit_o = word_q[PW'(W - 1) - ptr];

  // R7: pointer never leaves the loaded word
  p_ptr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(ptr) < len_q);

  // R3: a window start always points at the MSB
  p_start_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !load) |=> ptr == '0);

  // R3: without an event the position holds
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !start && !adv) |=> $stable(ptr));

endmodule

// File: rtl/slot_serial_out.sv
module slot_serial_out
  import slot_ser_pkg::*;
#(
  parameter int         CODE_W      = 5,
  parameter int         PCM_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] IDLE_MU     = 8'hFF,
  parameter logic [7:0] IDLE_A      = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              asck,
  input  logic              psck,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dir,
  input  logic              in_en,
  input  logic              in_law,
  input  logic [1:0]        in_rate,
  input  logic [CODE_W-1:0] in_code,
  input  logic [PCM_W-1:0]  in_pcm,
  output logic              tso,
  output logic              tso_oe,
  output logic              rso,
  output logic              rso_oe
);

  localparam int CLW = $clog2(CODE_W + 1);
  localparam int PLW = $clog2(PCM_W + 1);
  localparam int I_P = 0, I_A = 1, I_C = 2;

  logic [2:0] s_q, s_rise, s_fall;

  slot_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce, asck, psck}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );

  logic ce_q, ce_rise, ce_fall;
  assign ce_q    = s_q[I_C];
  assign ce_rise = s_rise[I_C];
  assign ce_fall = s_fall[I_C];

  logic accept;
  assign in_ready = ce_fall;
  assign accept   = in_valid & ce_fall;

  // slot ownership for the coming window
  logic slot_live, slot_dir;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_live <= 1'b0;
      slot_dir  <= 1'b0;
    end else if (ce_fall) begin
      slot_live <= accept;
      slot_dir  <= in_dir;
    end
  end

  logic [CODE_W-1:0] c_frame;
  logic [CLW-1:0]    c_len;

  slot_code_fmt #(.CODE_W(CODE_W)) u_fmt (
    .rate(rate_e'(in_rate)), .en(in_en), .code(in_code),
    .frame(c_frame), .len(c_len)
  );

  logic [PCM_W-1:0] p_word;
  assign p_word = in_en ? in_pcm : PCM_W'(in_law ? IDLE_A : IDLE_MU);

  logic c_bit, p_bit;

  slot_serializer #(.W(CODE_W)) u_code_ser (
    .clk(clk), .rst_n(rst_n),
    .load(accept & in_dir), .word(c_frame), .len(c_len),
    .start(ce_rise), .adv(s_rise[I_A] & ce_q), .bit_o(c_bit)
  );

  slot_serializer #(.W(PCM_W)) u_pcm_ser (
    .clk(clk), .rst_n(rst_n),
    .load(accept & ~in_dir), .word(p_word), .len(PLW'(PCM_W)),
    .start(ce_rise), .adv(s_rise[I_P] & ce_q), .bit_o(p_bit)
  );

  assign tso_oe = ce_q & slot_live & slot_dir;
  assign rso_oe = ce_q & slot_live & ~slot_dir;
  assign tso    = tso_oe & c_bit;
  assign rso    = rso_oe & p_bit;

  // R2: only one line may drive
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tso_oe && rso_oe));

  // R1: ready is a single-cycle pulse
  p_ready_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R2: after a hand-over the strobe is low, so nothing drives
  p_quiet_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (!tso_oe && !rso_oe));

endmodule

// File: tb/tb_slot_serial_out.sv
module tb_slot_serial_out;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ce, asck, psck, in_valid, in_ready, in_dir, in_en, in_law;
  logic [1:0] in_rate;
  logic [4:0] in_code;
  logic [7:0] in_pcm;
  logic tso, tso_oe, rso, rso_oe;

  slot_serial_out dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .asck(asck), .psck(psck),
    .in_valid(in_valid), .in_ready(in_ready), .in_dir(in_dir),
    .in_en(in_en), .in_law(in_law), .in_rate(in_rate),
    .in_code(in_code), .in_pcm(in_pcm),
    .tso(tso), .tso_oe(tso_oe), .rso(rso), .rso_oe(rso_oe)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // vector: {dir, en, law, rate[1:0], code[4:0], pcm[7:0], edges[3:0], exp[9:0]}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,2'b00,5'b01011,8'h00,4'd7,10'b1011101110},   // R4
    {1'b1,1'b1,1'b0,2'b01,5'b11101,8'h00,4'd7,10'b1010101010},   // R5
    {1'b1,1'b1,1'b0,2'b10,5'b11111,8'h00,4'd7,10'b1100110011},   // R5
    {1'b1,1'b1,1'b0,2'b10,5'b11110,8'h00,4'd9,10'b1000100010},   // R5
    {1'b1,1'b1,1'b0,2'b11,5'b10011,8'h00,4'd9,10'b1001110011},   // R6
    {1'b1,1'b1,1'b0,2'b11,5'b01101,8'h00,4'd9,10'b0110101101},   // R6
    {1'b1,1'b0,1'b0,2'b00,5'b11111,8'hFF,4'd5,10'b0000000000},   // R8
    {1'b1,1'b0,1'b1,2'b11,5'b11111,8'hFF,4'd6,10'b0000000000},   // R8
    {1'b0,1'b1,1'b0,2'b00,5'b11111,8'hA6,4'd9,10'b1010011010},   // R7
    {1'b0,1'b1,1'b1,2'b11,5'b00000,8'h3C,4'd9,10'b0011110000},   // R7
    {1'b0,1'b1,1'b0,2'b00,5'b00000,8'h81,4'd3,10'b1000000110},   // R7
    {1'b0,1'b0,1'b0,2'b00,5'b00000,8'h00,4'd9,10'b1111111111},   // R9
    {1'b0,1'b0,1'b1,2'b00,5'b00000,8'h00,4'd9,10'b1101010111}    // R9
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(bit on_code);
    if (on_code) asck = 1'b0; else psck = 1'b0;
    tick(4);
    if (on_code) asck = 1'b1; else psck = 1'b1;
    tick(6);
  endtask

  // hands over one word at a strobe fall, then opens the window
  task automatic load_word(logic [31:0] v, string req);
    bit got = 0;
    in_dir = v[31]; in_en = v[30]; in_law = v[29]; in_rate = v[28:27];
    in_code = v[26:22]; in_pcm = v[21:14];
    in_valid = 1'b1;
    ce = 1'b0;
    for (int i = 0; i < 12 && !got; i++) begin
      tick(1);
      if (in_ready) got = 1;
    end
    tick(1);
    in_valid = 1'b0;
    check(req, got, 1);
    tick(3);
    ce = 1'b1;
    tick(6);
  endtask

  task automatic bit_check(bit on_code, logic expb, string req);
    check(req, on_code ? tso_oe : rso_oe, 1);
    check("R2", on_code ? rso_oe : tso_oe, 0);
    check(req, on_code ? tso : rso, expb);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1; asck = 1'b1; psck = 1'b1; in_valid = 1'b0;
    in_dir = 1'b0; in_en = 1'b0; in_law = 1'b0; in_rate = 2'b00;
    in_code = '0; in_pcm = '0;
    tick(3);
    // R10: reset state
    check("R10", {tso_oe, rso_oe, tso, rso, in_ready}, 0);
    rst_n = 1'b1;
    tick(8);
    check("R10", {tso_oe, rso_oe, in_ready}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] w;
      int n;
      string tag;
      w = VEC[v];
      n = int'(w[13:10]);
      tag = w[31] ? (w[30] ? (w[28:27] == 2'b00 ? "R4" : (w[28:27] == 2'b11 ? "R6" : "R5")) : "R8")
                  : (w[30] ? "R7" : "R9");
      load_word(w, "R1");
      bit_check(w[31], w[9], "R3");
      for (int k = 1; k <= n; k++) begin
        pulse(w[31]);
        bit_check(w[31], w[9-k], tag);
      end
    end

    // R3: wrong bit clock on the code line is ignored
    load_word({1'b1,1'b1,1'b0,2'b00,5'b01011,8'h00,4'd0,10'd0}, "R1");
    pulse(1'b1);
    bit_check(1'b1, 1'b0, "R3");
    pulse(1'b0);
    bit_check(1'b1, 1'b0, "R3");
    pulse(1'b1);
    bit_check(1'b1, 1'b1, "R3");

    // R3: wrong bit clock on the PCM line is ignored
    load_word({1'b0,1'b1,1'b0,2'b00,5'b00000,8'h80,4'd0,10'd0}, "R1");
    pulse(1'b1);
    bit_check(1'b0, 1'b1, "R3");
    pulse(1'b0);
    bit_check(1'b0, 1'b0, "R3");

    // R1/R2/R11: strobe fall with no word offered
    begin
      int pulses = 0;
      ce = 1'b0;
      for (int i = 0; i < 10; i++) begin
        tick(1);
        if (in_ready) pulses++;
      end
      check("R1", pulses, 1);
      check("R2", {tso_oe, rso_oe}, 0);
      check("R11", {tso, rso}, 0);
      ce = 1'b1;
      tick(6);
      check("R1", {tso_oe, rso_oe}, 0);
      pulse(1'b1);
      pulse(1'b0);
      check("R11", {tso, rso, tso_oe, rso_oe}, 0);
    end

    // R2: enable drops with the strobe after a live window
    load_word({1'b1,1'b1,1'b0,2'b11,5'b11111,8'h00,4'd0,10'd0}, "R1");
    bit_check(1'b1, 1'b1, "R6");
    ce = 1'b0;
    tick(4);
    check("R2", {tso_oe, rso_oe}, 0);
    check("R11", tso, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule